// File: doc/BRIEF.md
# Byte-Wide Stack Machine Core

This block is a compact multi-cycle processor with byte-wide data. Its program is held in an external byte-addressed ROM that the core reads through a single address/data pair. Each instruction is two bytes: the first byte read is the operation code and the second is the operand. The core keeps three working registers, a program counter, a stack pointer, a constant base pointer and a one-bit-valued flag register. It also holds a private 256-byte stack memory. Values move between registers only by pushing them onto that stack and popping them off again.

The sequencer has four named states. FETCH_OP drives the PC onto the ROM address and latches the operation byte, then always moves to FETCH_ARG. FETCH_ARG drives PC+1 and latches the operand byte, then always moves to EXEC. EXEC performs the instruction. From EXEC the sequencer goes to HALT when the operation is the break code, and to FETCH_OP for every other code. HALT is terminal until reset.

The flag has an inverted sense for comparisons: 0 means the operands were equal. The same flag also records the carry out of an addition and the borrow out of a subtraction. A system integrator watches the `halted` output and the debug register outputs to see when a program has finished and what it left behind.

Top module: `stack8_core`

## Requirements
- R1: While reset is held and right after it, A, B, C, PC and FLAGS read 0, SP and BP read 0xFF, and `halted` is low.
- R2: Every instruction takes three clocks. The opcode byte is read at address PC, then the operand byte at PC+1, then the instruction executes. Registers, PC, SP and FLAGS change only on the execute clock, and PC advances by 2 for every instruction that neither jumps nor halts.
- R3: The opcode values are: 0x00 no-op, 0x01 add, 0x02 subtract, 0x03 push register, 0x04 push literal, 0x05 pop, 0x06 jump, 0x07 jump-if-flag-zero, 0x08 jump-if-flag-nonzero, 0x09 compare, 0x0A break.
- R4: Register codes are 0=A, 1=B, 2=C. Add, subtract and compare take the first register from operand bits [5:4] and the second from bits [1:0]. Push and pop name their register in bits [1:0]. Code 3 reads as 0, and a write to code 3 is dropped.
- R5: Add writes (first + second) mod 256 into the first register and sets FLAGS to 1 on unsigned carry out, or to 0 otherwise.
- R6: Subtract writes (first − second) mod 256 into the first register and sets FLAGS to 1 when second > first (unsigned borrow), or to 0 otherwise.
- R7: Compare sets FLAGS to 0 when the two registers are equal and to 1 otherwise, and changes no register.
- R8: Jump loads PC with the operand. Jump-if-zero does so only when FLAGS is 0, and jump-if-nonzero only when FLAGS is not 0. An untaken conditional advances PC by 2.
- R9: Push register and push literal store the value at stack address SP and then decrement SP modulo 256. Push literal stores the operand byte itself.
- R10: Pop first increments SP modulo 256, then loads the selected register from stack address SP.
- R11: Break raises `halted`, which stays high until reset. PC keeps the address of the break instruction, and no register, PC, SP or FLAGS value changes afterwards.
- R12: The no-op code and every code above 0x0A only advance PC by 2.
- R13: The counting-loop program (A=3 and C=1 set through the stack, then C added to B until B equals A) halts with A=3, B=3, C=1, FLAGS=0 and PC=0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_addr | output | 8 | Program ROM byte address |
| rom_data | input | 8 | Program ROM byte returned for `rom_addr` in the same cycle |
| halted | output | 1 | High after a break instruction until reset |
| dbg_a | output | 8 | Register A |
| dbg_b | output | 8 | Register B |
| dbg_c | output | 8 | Register C |
| dbg_pc | output | 8 | Program counter |
| dbg_sp | output | 8 | Stack pointer |
| dbg_bp | output | 8 | Base pointer |
| dbg_flags | output | 8 | Flag register, value 0 or 1 |

## Verification
The bench builds the core with its default widths: 8-bit data, which also makes the PC 8 bits wide, and an 8-bit stack address that gives a full 256-byte stack. With these widths the carry out of 0xF0+0x20 and the borrow of 0x00−0x10 fall at the real byte boundary. Jump targets anywhere in the byte-addressed program space are reachable. Two programs run: the counting loop, and a program that exercises every opcode, an undefined opcode, the unused register code, and branches both taken and not taken.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    typedef enum logic [1:0] {
        ST_FETCH_OP  = 2'd0,
        ST_FETCH_ARG = 2'd1,
        ST_EXEC      = 2'd2,
        ST_HALT      = 2'd3
    } state_e;

    // Operation byte values; their numbers are fixed by the program format.
    localparam logic [7:0] OP_NOP   = 8'h00;
    localparam logic [7:0] OP_ADD   = 8'h01;
    localparam logic [7:0] OP_SUB   = 8'h02;
    localparam logic [7:0] OP_PUSH  = 8'h03;
    localparam logic [7:0] OP_PUSHL = 8'h04;
    localparam logic [7:0] OP_POP   = 8'h05;
    localparam logic [7:0] OP_JMP   = 8'h06;
    localparam logic [7:0] OP_JZ    = 8'h07;
    localparam logic [7:0] OP_JNZ   = 8'h08;
    localparam logic [7:0] OP_CMP   = 8'h09;
    localparam logic [7:0] OP_BRK   = 8'h0A;

    localparam int NUM_REGS = 3;
    localparam int REG_IDX_W = 2;

endpackage

// File: rtl/cpu8_regs.sv
module cpu8_regs
    import cpu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [REG_IDX_W-1:0]     rd1_idx,
    input  logic [REG_IDX_W-1:0]     rd2_idx,
    output logic [DW-1:0]            rd1_val,
    output logic [DW-1:0]            rd2_val,
    input  logic                     wr_en,
    input  logic [REG_IDX_W-1:0]     wr_idx,
    input  logic [DW-1:0]            wr_val,
    output logic [NUM_REGS*DW-1:0]   all_regs
);

    logic [DW-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en && (wr_idx == REG_IDX_W'(g))) begin
                regs_q[g] <= wr_val;
            end
        end
        assign all_regs[g*DW +: DW] = regs_q[g];
    end

    // Unused register code reads as zero.
    always_comb begin
        rd1_val = '0;
        rd2_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd1_idx == REG_IDX_W'(i)) rd1_val = regs_q[i];
            if (rd2_idx == REG_IDX_W'(i)) rd2_val = regs_q[i];
        end
    end

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic          do_sub,
    output logic [DW-1:0] result,
    output logic          carry,
    output logic          differ
);

    logic [DW:0] wide;

    // Top bit is carry for add and borrow for subtract.
    always_comb begin
        if (do_sub) wide = {1'b0, lhs} - {1'b0, rhs};
        else        wide = {1'b0, lhs} + {1'b0, rhs};
    end

    assign result = wide[DW-1:0];
    assign carry  = wide[DW];
    assign differ = (lhs != rhs);

endmodule

// File: rtl/cpu8_stack_ram.sv
module cpu8_stack_ram #(
    parameter int DW  = 8,
    parameter int SAW = 8
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [SAW-1:0] wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [SAW-1:0] rd_addr,
    output logic [DW-1:0]  rd_data
);

    localparam int DEPTH = 1 << SAW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/stack8_core.sv
module stack8_core
    import cpu8_pkg::*;
#(
    parameter int DW  = 8,
    parameter int SAW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] rom_addr,
    input  logic [DW-1:0] rom_data,
    output logic          halted,
    output logic [DW-1:0] dbg_a,
    output logic [DW-1:0] dbg_b,
    output logic [DW-1:0] dbg_c,
    output logic [DW-1:0] dbg_pc,
    output logic [DW-1:0] dbg_sp,
    output logic [DW-1:0] dbg_bp,
    output logic [DW-1:0] dbg_flags
);

    localparam logic [DW-1:0] PC_STEP  = DW'(2);
    localparam logic [DW-1:0] SP_RESET = {DW{1'b1}};

    state_e         state_q, state_d;
    logic [DW-1:0]  pc_q, pc_d;
    logic [DW-1:0]  sp_q, sp_d;
    logic [DW-1:0]  flags_q, flags_d;
    logic [DW-1:0]  op_q, arg_q;
    logic           halted_q, halted_d;

    logic [DW-1:0]  rd1_val, rd2_val;
    logic           rf_we;
    logic [REG_IDX_W-1:0] rf_widx;
    logic [DW-1:0]  rf_wval;
    logic [NUM_REGS*DW-1:0] regs_flat;

    logic [DW-1:0]  alu_res;
    logic           alu_carry, alu_differ, alu_sub;

    logic           ram_we;
    logic [DW-1:0]  ram_wdata, ram_rdata;
    logic [DW-1:0]  sp_inc;

    assign sp_inc = sp_q + DW'(1);

    cpu8_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd1_idx  (arg_q[5:4]),
        .rd2_idx  (arg_q[1:0]),
        .rd1_val  (rd1_val),
        .rd2_val  (rd2_val),
        .wr_en    (rf_we),
        .wr_idx   (rf_widx),
        .wr_val   (rf_wval),
        .all_regs (regs_flat)
    );

    cpu8_alu #(.DW(DW)) u_alu (
        .lhs    (rd1_val),
        .rhs    (rd2_val),
        .do_sub (alu_sub),
        .result (alu_res),
        .carry  (alu_carry),
        .differ (alu_differ)
    );

    cpu8_stack_ram #(.DW(DW), .SAW(SAW)) u_stack (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr (sp_q[SAW-1:0]),
        .wr_data (ram_wdata),
        .rd_addr (sp_inc[SAW-1:0]),
        .rd_data (ram_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH_OP;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_OP:  state_d = ST_FETCH_ARG;
            ST_FETCH_ARG: state_d = ST_EXEC;
            ST_EXEC:      state_d = (op_q == OP_BRK) ? ST_HALT : ST_FETCH_OP;
            ST_HALT:      state_d = ST_HALT;
        endcase
    end

    // Outputs and datapath controls per state
    always_comb begin
        rom_addr  = pc_q;
        pc_d      = pc_q;
        sp_d      = sp_q;
        flags_d   = flags_q;
        halted_d  = halted_q;
        rf_we     = 1'b0;
        rf_widx   = arg_q[5:4];
        rf_wval   = alu_res;
        ram_we    = 1'b0;
        ram_wdata = rd2_val;
        alu_sub   = (op_q == OP_SUB);
        unique case (state_q)
            ST_FETCH_OP:  rom_addr = pc_q;
            ST_FETCH_ARG: rom_addr = pc_q + DW'(1);
            ST_HALT:      rom_addr = pc_q;
            ST_EXEC: begin
                pc_d = pc_q + PC_STEP;
                case (op_q)
                    OP_ADD, OP_SUB: begin
                        rf_we   = 1'b1;
                        flags_d = DW'(alu_carry);
                    end
                    OP_PUSH: begin
                        ram_we = 1'b1;
                        sp_d   = sp_q - DW'(1);
                    end
                    OP_PUSHL: begin
                        ram_we    = 1'b1;
                        ram_wdata = arg_q;
                        sp_d      = sp_q - DW'(1);
                    end
                    OP_POP: begin
                        sp_d    = sp_inc;
                        rf_we   = 1'b1;
                        rf_widx = arg_q[1:0];
                        rf_wval = ram_rdata;
                    end
                    OP_JMP: pc_d = arg_q;
                    OP_JZ:  if (flags_q == '0) pc_d = arg_q;
                    OP_JNZ: if (flags_q != '0) pc_d = arg_q;
                    OP_CMP: flags_d = DW'(alu_differ);
                    OP_BRK: begin
                        pc_d     = pc_q;
                        halted_d = 1'b1;
                    end
                    default: ;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q     <= '0;
            sp_q     <= SP_RESET;
            flags_q  <= '0;
            op_q     <= '0;
            arg_q    <= '0;
            halted_q <= 1'b0;
        end else begin
            if (state_q == ST_FETCH_OP)  op_q  <= rom_data;
            if (state_q == ST_FETCH_ARG) arg_q <= rom_data;
            pc_q     <= pc_d;
            sp_q     <= sp_d;
            flags_q  <= flags_d;
            halted_q <= halted_d;
        end
    end

    assign halted    = halted_q;
    assign dbg_a     = regs_flat[0*DW +: DW];
    assign dbg_b     = regs_flat[1*DW +: DW];
    assign dbg_c     = regs_flat[2*DW +: DW];
    assign dbg_pc    = pc_q;
    assign dbg_sp    = sp_q;
    assign dbg_bp    = SP_RESET;
    assign dbg_flags = flags_q;

endmodule

// File: rtl/stack8_core_chk.sv
module stack8_core_chk
    import cpu8_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input state_e        state_q,
    input logic [DW-1:0] op_q,
    input logic [DW-1:0] rom_addr,
    input logic [DW-1:0] pc,
    input logic [DW-1:0] sp,
    input logic [DW-1:0] a,
    input logic [DW-1:0] b,
    input logic [DW-1:0] c,
    input logic [DW-1:0] flags,
    input logic          halted
);

    // R2
    arg_fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_ARG) |-> (rom_addr == DW'(pc + DW'(1))));

    // R2
    change_only_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(a) || !$stable(b) || !$stable(c) || !$stable(flags) || !$stable(pc))
        |-> ($past(state_q) == ST_EXEC));

    // R7
    cmp_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) == ST_EXEC) && ($past(op_q) == OP_CMP))
        |-> ($stable(a) && $stable(b) && $stable(c)));

    // R11
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(sp) && $stable(a)
                    && $stable(b) && $stable(c) && $stable(flags)));

    // R9
    sp_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> ((sp == DW'($past(sp) + DW'(1))) || (sp == DW'($past(sp) - DW'(1)))));

endmodule

bind stack8_core stack8_core_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .op_q     (op_q),
    .rom_addr (rom_addr),
    .pc       (dbg_pc),
    .sp       (dbg_sp),
    .a        (dbg_a),
    .b        (dbg_b),
    .c        (dbg_c),
    .flags    (dbg_flags),
    .halted   (halted)
);

// File: tb/sim_stack8_core.sv
module sim_stack8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rom_addr, rom_data;
    logic       halted;
    logic [7:0] dbg_a, dbg_b, dbg_c, dbg_pc, dbg_sp, dbg_bp, dbg_flags;

    int checks = 0;
    int errors = 0;
    bit tracing = 1'b0;

    logic [7:0] rom [256];

    always #5 clk = ~clk;

    assign rom_data = rom[rom_addr];

    stack8_core u0 (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .halted(halted), .dbg_a(dbg_a), .dbg_b(dbg_b), .dbg_c(dbg_c),
        .dbg_pc(dbg_pc), .dbg_sp(dbg_sp), .dbg_bp(dbg_bp), .dbg_flags(dbg_flags)
    );

    // Behavioural reference model
    int m_reg [3];
    int m_mem [256];
    int m_pc, m_sp, m_flags, m_phase;
    bit m_halt;

    function automatic int rv(int idx);
        return (idx < 3) ? m_reg[idx] : 0;
    endfunction

    task automatic m_exec();
        int op, arg, r1, r2, s;
        op  = int'(rom[m_pc[7:0]]);
        arg = int'(rom[8'(m_pc + 1)]);
        r1  = (arg >> 4) & 3;
        r2  = arg & 3;
        s   = (m_pc + 2) & 255;
        case (op)
            1: begin
                int t = rv(r1) + rv(r2);
                if (r1 < 3) m_reg[r1] = t & 255;
                m_flags = (t > 255) ? 1 : 0;
                m_pc = s;
            end
            2: begin
                int t = rv(r1) - rv(r2);
                if (r1 < 3) m_reg[r1] = t & 255;
                m_flags = (t < 0) ? 1 : 0;
                m_pc = s;
            end
            3: begin m_mem[m_sp] = rv(r2); m_sp = (m_sp + 255) & 255; m_pc = s; end
            4: begin m_mem[m_sp] = arg;    m_sp = (m_sp + 255) & 255; m_pc = s; end
            5: begin
                m_sp = (m_sp + 1) & 255;
                if (r2 < 3) m_reg[r2] = m_mem[m_sp];
                m_pc = s;
            end
            6: m_pc = arg;
            7: m_pc = (m_flags == 0) ? arg : s;
            8: m_pc = (m_flags != 0) ? arg : s;
            9: begin m_flags = (rv(r1) != rv(r2)) ? 1 : 0; m_pc = s; end
            10: m_halt = 1'b1;
            default: m_pc = s;
        endcase
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_reg[i] = 0;
            m_pc = 0; m_sp = 255; m_flags = 0; m_phase = 0; m_halt = 1'b0;
        end else if (!m_halt) begin
            if (m_phase == 2) begin
                m_exec();
                m_phase = 0;
            end else begin
                m_phase = m_phase + 1;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R2 timing, every field)
    always @(negedge clk) begin
        if (rst_n && tracing) begin
            chk("R2 trace A",     int'(dbg_a),     m_reg[0]);
            chk("R2 trace B",     int'(dbg_b),     m_reg[1]);
            chk("R2 trace C",     int'(dbg_c),     m_reg[2]);
            chk("R2 trace PC",    int'(dbg_pc),    m_pc);
            chk("R2 trace SP",    int'(dbg_sp),    m_sp);
            chk("R2 trace FLAGS", int'(dbg_flags), m_flags);
            chk("R11 trace halted", int'(halted),  int'(m_halt));
            if (m_phase == 1) chk("R2 operand address", int'(rom_addr), (m_pc + 1) & 255);
        end
    end

    task automatic put(int addr, int op, int arg);
        rom[addr[7:0]]     = op[7:0];
        rom[8'(addr + 1)]  = arg[7:0];
    endtask

    task automatic run_program();
        int cyc;
        tracing = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 A", int'(dbg_a), 0);
        chk("R1 B", int'(dbg_b), 0);
        chk("R1 C", int'(dbg_c), 0);
        chk("R1 PC", int'(dbg_pc), 0);
        chk("R1 FLAGS", int'(dbg_flags), 0);
        chk("R1 SP", int'(dbg_sp), 255);
        chk("R1 BP", int'(dbg_bp), 255);
        chk("R1 halted", int'(halted), 0);
        rst_n = 1'b1;
        tracing = 1'b1;
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) chk("R11 watchdog halted", 0, 1);
        repeat (12) @(negedge clk);
        chk("R11 halted held", int'(halted), 1);
        chk("R1 BP after run", int'(dbg_bp), 255);
    endtask

    initial begin
        // Program 1: counting loop (R13)
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
        put(8'h00, 8'h04, 3);     // push literal 3
        put(8'h02, 8'h05, 0);     // pop A
        put(8'h04, 8'h04, 1);     // push literal 1
        put(8'h06, 8'h05, 2);     // pop C
        put(8'h08, 8'h09, 8'h01); // compare A,B
        put(8'h0A, 8'h07, 8'h10); // jump if equal to exit
        put(8'h0C, 8'h01, 8'h12); // B += C
        put(8'h0E, 8'h06, 8'h08); // back to compare
        put(8'h10, 8'h0A, 0);     // break
        run_program();
        chk("R13 A", int'(dbg_a), 3);
        chk("R13 B", int'(dbg_b), 3);
        chk("R13 C", int'(dbg_c), 1);
        chk("R13 FLAGS", int'(dbg_flags), 0);
        chk("R13 PC", int'(dbg_pc), 8'h10);

        // Program 2: every opcode (R3) and corner cases
        for (int i = 0; i < 256; i++) rom[i] = 8'h00;
        put(8'h00, 8'h04, 8'hF0); // push literal (R9)
        put(8'h02, 8'h05, 0);     // pop A = F0 (R10)
        put(8'h04, 8'h04, 8'h20);
        put(8'h06, 8'h05, 1);     // B = 20
        put(8'h08, 8'h01, 8'h01); // A = A+B = 10, carry (R5)
        put(8'h0A, 8'h08, 8'h0E); // jump if nonzero, taken (R8)
        put(8'h0C, 8'h0A, 0);     // skipped break
        put(8'h0E, 8'h02, 8'h10); // B = B-A = 10, no borrow (R6)
        put(8'h10, 8'h02, 8'h01); // A = A-B = 0
        put(8'h12, 8'h02, 8'h01); // A = 0-10 = F0, borrow (R6)
        put(8'h14, 8'h07, 8'h00); // jump if zero, not taken (R8)
        put(8'h16, 8'h00, 8'h77); // no-op (R12)
        put(8'h18, 8'hF3, 8'h55); // undefined code (R12)
        put(8'h1A, 8'h03, 0);     // push A
        put(8'h1C, 8'h03, 3);     // push unused code: stores 0 (R4)
        put(8'h1E, 8'h05, 3);     // pop into unused code: dropped (R4)
        put(8'h20, 8'h05, 2);     // pop C = F0
        put(8'h22, 8'h09, 8'h20); // compare C,A equal -> 0 (R7)
        put(8'h24, 8'h07, 8'h28); // jump if zero, taken
        put(8'h26, 8'h0A, 0);
        put(8'h28, 8'h09, 8'h21); // compare C,B differ -> 1 (R7)
        put(8'h2A, 8'h06, 8'h2E); // jump (R8)
        put(8'h2C, 8'h0A, 0);
        put(8'h2E, 8'h0A, 0);     // break (R11)
        run_program();
        chk("R5 R6 A", int'(dbg_a), 8'hF0);
        chk("R6 B", int'(dbg_b), 8'h10);
        chk("R4 R10 C", int'(dbg_c), 8'hF0);
        chk("R7 FLAGS", int'(dbg_flags), 1);
        chk("R9 R10 SP", int'(dbg_sp), 8'hFF);
        chk("R8 R11 R12 PC", int'(dbg_pc), 8'h2E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule